// File: doc/BRIEF.md
# Serial Hop Acquisition Controller

This controller brings a frequency-hopping receiver into code alignment one trial phase at a time. On every hop a local pseudo-noise register supplies the frequency index that drives the synthesizer. A digitized per-hop decision, `match`, is high when the local and received frequencies agree. The controller adds these decisions over a fixed dwell of hops. It then compares the total with a programmable threshold.

If the total reaches the threshold, the block raises a lock flag. The code generator keeps running so that a tracking loop can take over. If the total falls short, the block retards its local code by one hop and starts a new dwell from zero. Once every phase of the code period has failed, the search gives up and sets a timeout flag.

A `start` pulse begins a search from the loaded seed. The mixer, envelope detector and synthesizer sit outside the block.

Top module: `hacq_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, the block is idle. `busy`, `locked`, `timeout` and `slip_pulse` are 0, and `freq_idx` equals the low IDX_W bits of the seed (default seed 7'h01, so `freq_idx` is 1).
- R2: The code register has LFSR_W bits. Its next value is {state[LFSR_W-2:0], p}, where p is the XOR of the state bits selected by the tap mask (default 7'h60, so bits 6 and 5). `freq_idx` is its low IDX_W bits. It advances once per `hop_stb` during a dwell and while locked, holds otherwise, and is never zero.
- R3: A `start` while idle or locked loads the seed, clears the sum, the failure count, `timeout` and `locked`, and begins a dwell. A `start` while `busy` is high has no effect. A `hop_stb` in the same cycle as an accepted `start` is not counted and does not advance the code.
- R4: A dwell takes DWELL_HOPS (default 8) hop strobes. Each strobe adds `match` to the sum. The cycle after the last strobe is a single decision cycle.
- R5: In the decision cycle, a sum greater than or equal to `threshold` sets `locked`. `locked` then holds, with `busy` low, until the next accepted `start`.
- R6: A failed decision, while phases remain, waits for the next `hop_stb`. That strobe does not advance the code and its `match` is ignored. `slip_pulse` is high for exactly the one cycle after it, and a new dwell starts from a zero sum.
- R7: The failed dwell after which 2^LFSR_W-1 dwells have failed since `start` sets `timeout` and returns the block to idle. `timeout` holds until the next accepted `start`.
- R8: `busy` is high exactly while a dwell, a decision or a pending slip is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search from the seed |
| hop_stb | input | 1 | One-cycle strobe per hop, at least two cycles apart |
| match | input | 1 | Local and received frequencies agree on this hop |
| threshold | input | SUM_W | Minimum match total that declares lock |
| freq_idx | output | IDX_W | Local synthesizer frequency index |
| slip_pulse | output | 1 | One-cycle pulse after a swallowed hop |
| locked | output | 1 | Acquisition declared |
| busy | output | 1 | Search in progress |
| timeout | output | 1 | Every phase tried without success |

## Verification
Two events can fall in the same cycle: a restart `start` and a `hop_stb`, either while locked or while idle. The bench drives both on one edge. It then expects `freq_idx` to show the seed, so the code did not advance, and expects the dwell to take a full DWELL_HOPS further strobes before it decides. The bench also places a hop strobe on the swallowed slip hop, right after a failed decision, and checks that `freq_idx` did not move. A behavioural model compares every output on every cycle against these expectations.

// File: rtl/hacq_pkg.sv
package hacq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DWELL  = 3'd1,
        ST_DECIDE = 3'd2,
        ST_SLIP   = 3'd3,
        ST_LOCKED = 3'd4
    } acq_state_t;

    typedef struct packed {
        logic load;    // restart from seed
        logic adv;     // step the code register
        logic clr;     // clear sum and hop count
        logic acc_en;  // count this strobe into the sum
    } acq_ctl_t;

    function automatic logic parity32(input logic [31:0] v);
        logic p;
        p = 1'b0;
        for (int i = 0; i < 32; i++) begin
            p = p ^ v[i];
        end
        return p;
    endfunction

    function automatic logic is_searching(input acq_state_t s);
        return (s == ST_DWELL) || (s == ST_DECIDE) || (s == ST_SLIP);
    endfunction

endpackage

// File: rtl/hacq_pn_gen.sv
module hacq_pn_gen #(
    parameter int W = 7,
    parameter logic [W-1:0] TAPS = 7'h60,
    parameter logic [W-1:0] SEED = 7'h01,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    logic [W-1:0] code_q;
    logic [W-1:0] code_nxt;
    logic         fb;

    always_comb begin
        fb       = hacq_pkg::parity32(32'(code_q & TAPS));
        code_nxt = {code_q[W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            code_q <= SEED;
        end else if (adv) begin
            code_q <= code_nxt;
        end
    end

    assign idx = code_q[IDX_W-1:0];

    // R2: a maximal-length register never reaches the all-zero lockup state
    a_r2_never_zero: assert property (@(posedge clk) disable iff (rst)
        code_q != '0);

    // R2: without a step or reload the code phase holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(code_q));

endmodule

// File: rtl/hacq_dwell_acc.sv
module hacq_dwell_acc #(
    parameter int N = 8,
    parameter int SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc_en,
    input  logic             match,
    output logic [SUM_W-1:0] sum,
    output logic             last_hop
);
    localparam int CNT_W = $clog2(N + 1);
    localparam logic [CNT_W-1:0] LAST_HOP = CNT_W'(N - 1);

    logic [CNT_W-1:0] hop_cnt_q;
    logic [SUM_W-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hop_cnt_q <= '0;
            sum_q     <= '0;
        end else if (acc_en) begin
            hop_cnt_q <= hop_cnt_q + 1'b1;
            sum_q     <= sum_q + SUM_W'(match);
        end
    end

    assign sum      = sum_q;
    assign last_hop = acc_en && (hop_cnt_q == LAST_HOP);

    // R4: the total cannot exceed the number of hops counted so far
    a_r4_sum_bound: assert property (@(posedge clk) disable iff (rst)
        32'(sum_q) <= 32'(hop_cnt_q));

    // R4: the hop count never runs past one dwell
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        32'(hop_cnt_q) <= N);

endmodule

// File: rtl/hacq_fsm.sv
module hacq_fsm
    import hacq_pkg::*;
#(
    parameter int FAIL_W = 7,
    parameter int PHASES = 127,
    parameter int SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hop_stb,
    input  logic             last_hop,
    input  logic [SUM_W-1:0] sum,
    input  logic [SUM_W-1:0] threshold,
    output acq_ctl_t         ctl,
    output logic             busy,
    output logic             locked,
    output logic             timeout,
    output logic             slip_pulse
);
    localparam logic [FAIL_W-1:0] LAST_FAIL = FAIL_W'(PHASES - 1);

    acq_state_t        state_q, state_d;
    logic [FAIL_W-1:0] fail_q;
    logic              timeout_q;
    logic              slip_q;
    logic              load;
    logic              met;

    always_comb begin
        load       = start && ((state_q == ST_IDLE) || (state_q == ST_LOCKED));
        met        = (sum >= threshold);
        ctl.load   = load;
        ctl.clr    = load || (state_q == ST_DECIDE);
        ctl.acc_en = hop_stb && (state_q == ST_DWELL);
        ctl.adv    = hop_stb && !load &&
                     ((state_q == ST_DWELL) || (state_q == ST_LOCKED));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = ST_DWELL;
            ST_DWELL:  if (last_hop) state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (met) begin
                    state_d = ST_LOCKED;
                end else if (fail_q == LAST_FAIL) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_SLIP;
                end
            end
            ST_SLIP:   if (hop_stb) state_d = ST_DWELL;
            ST_LOCKED: if (load) state_d = ST_DWELL;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            fail_q    <= '0;
            timeout_q <= 1'b0;
            slip_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            slip_q  <= (state_q == ST_SLIP) && hop_stb;
            if (load) begin
                fail_q    <= '0;
                timeout_q <= 1'b0;
            end else if ((state_q == ST_DECIDE) && !met) begin
                if (fail_q == LAST_FAIL) begin
                    timeout_q <= 1'b1;
                end else begin
                    fail_q <= fail_q + 1'b1;
                end
            end
        end
    end

    assign busy       = is_searching(state_q);
    assign locked     = (state_q == ST_LOCKED);
    assign timeout    = timeout_q;
    assign slip_pulse = slip_q;

    // R5: lock persists until a restart
    a_r5_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (locked && !start) |=> locked);

    // R6: the slip indication is a single-cycle pulse
    a_r6_slip_single: assert property (@(posedge clk) disable iff (rst)
        slip_pulse |=> !slip_pulse);

    // R6: a slip pulse always lands in a fresh dwell
    a_r6_slip_in_dwell: assert property (@(posedge clk) disable iff (rst)
        slip_pulse |-> (busy && !locked));

    // R7: a timed-out search is idle and unlocked
    a_r7_timeout_idle: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (!busy && !locked));

    // R3: a start during a dwell leaves the search running
    a_r3_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || locked || timeout));

endmodule

// File: rtl/hacq_ctrl.sv
module hacq_ctrl #(
    parameter int LFSR_W = 7,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 7'h60,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 7'h01,
    parameter int IDX_W = 4,
    parameter int DWELL_HOPS = 8,
    localparam int SUM_W = $clog2(DWELL_HOPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hop_stb,
    input  logic             match,
    input  logic [SUM_W-1:0] threshold,
    output logic [IDX_W-1:0] freq_idx,
    output logic             slip_pulse,
    output logic             locked,
    output logic             busy,
    output logic             timeout
);
    localparam int PHASES = (1 << LFSR_W) - 1;

    hacq_pkg::acq_ctl_t ctl;
    logic [SUM_W-1:0]   sum;
    logic               last_hop;

    hacq_pn_gen #(
        .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .IDX_W(IDX_W)
    ) u_pn (
        .clk(clk), .rst(rst), .load(ctl.load), .adv(ctl.adv), .idx(freq_idx)
    );

    hacq_dwell_acc #(
        .N(DWELL_HOPS), .SUM_W(SUM_W)
    ) u_acc (
        .clk(clk), .rst(rst), .clr(ctl.clr), .acc_en(ctl.acc_en),
        .match(match), .sum(sum), .last_hop(last_hop)
    );

    hacq_fsm #(
        .FAIL_W(LFSR_W), .PHASES(PHASES), .SUM_W(SUM_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .hop_stb(hop_stb),
        .last_hop(last_hop), .sum(sum), .threshold(threshold),
        .ctl(ctl), .busy(busy), .locked(locked), .timeout(timeout),
        .slip_pulse(slip_pulse)
    );

endmodule

// File: tb/sim_hacq_ctrl.sv
module sim_hacq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int W     = 7;
    localparam int TAPS  = 'h60;
    localparam int SEED  = 'h01;
    localparam int IMASK = 15;
    localparam int NPH   = (1 << W) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       hop_stb = 1'b0;
    logic       match = 1'b0;
    logic [3:0] threshold = 4'd0;
    logic [3:0] freq_idx;
    logic       slip_pulse, locked, busy, timeout;

    int checks = 0;
    int fails = 0;
    int cyc_n = 0;
    bit done = 0;

    hacq_ctrl u0 (
        .clk(clk), .rst(rst), .start(start), .hop_stb(hop_stb), .match(match),
        .threshold(threshold), .freq_idx(freq_idx), .slip_pulse(slip_pulse),
        .locked(locked), .busy(busy), .timeout(timeout)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int step(input int s);
        int fb;
        fb = 0;
        for (int i = 0; i < W; i++) begin
            if (((TAPS >> i) & 1) == 1) fb = fb ^ ((s >> i) & 1);
        end
        return ((s << 1) | fb) & ((1 << W) - 1);
    endfunction

    // behavioural reference: 0 idle, 1 dwell, 2 decide, 3 slip, 4 locked
    int m_st = 0, m_code = SEED, m_sum = 0, m_cnt = 0, m_fails = 0;
    int m_to = 0, m_slip = 0;
    bit m_valid = 0;

    always @(posedge clk) begin
        m_valid = 1;
        if (rst) begin
            m_st = 0; m_code = SEED; m_sum = 0; m_cnt = 0;
            m_fails = 0; m_to = 0; m_slip = 0;
        end else begin
            m_slip = 0;
            if (start && (m_st == 0 || m_st == 4)) begin
                m_code = SEED; m_sum = 0; m_cnt = 0; m_fails = 0; m_to = 0;
                m_st = 1;
            end else begin
                case (m_st)
                    1: if (hop_stb) begin
                        m_sum = m_sum + int'(match);
                        m_cnt = m_cnt + 1;
                        m_code = step(m_code);
                        if (m_cnt == N) m_st = 2;
                    end
                    2: begin
                        if (m_sum >= int'(threshold)) m_st = 4;
                        else if (m_fails == NPH - 1) begin m_to = 1; m_st = 0; end
                        else begin m_fails = m_fails + 1; m_st = 3; end
                        m_sum = 0; m_cnt = 0;
                    end
                    3: if (hop_stb) begin m_slip = 1; m_st = 1; end
                    4: if (hop_stb) m_code = step(m_code);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("R2 freq_idx", int'(freq_idx), m_code & IMASK);
            chk("R8 busy", int'(busy), int'(m_st >= 1 && m_st <= 3));
            chk("R5 locked", int'(locked), int'(m_st == 4));
            chk("R7 timeout", int'(timeout), m_to);
            chk("R6 slip_pulse", int'(slip_pulse), m_slip);
        end
    end

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n == 100000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc_n);
            finish_up();
        end
    end

    // stimulus: transmitter code and per-cycle drive
    int tx = SEED;

    task automatic cyc(input bit hs, input bit m, input bit st);
        @(negedge clk);
        hop_stb = hs; match = m; start = st;
    endtask

    task automatic do_hop(input int mode, input bit forced);
        // mode 0: match from transmitter comparison, 1: forced value
        bit m;
        m = (mode == 0) ? ((tx & IMASK) == int'(freq_idx)) : forced;
        cyc(1'b1, m, 1'b0);
        tx = step(tx);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_start(input int tx_init);
        cyc(1'b0, 1'b0, 1'b1);
        tx = tx_init;
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic dwell_pattern(input int k);
        for (int i = 0; i < N; i++) do_hop(1, i < k);
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        int behind, hits, f;
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset freq_idx", int'(freq_idx), SEED & IMASK);
        @(negedge clk); rst = 1'b0;
        cyc(1'b0, 1'b0, 1'b0);
        chk("R1 after reset locked", int'(locked), 0);

        // aligned reception locks after one dwell
        threshold = 4'd8;
        do_start(SEED);
        chk("R8 busy on start", int'(busy), 1);
        for (int i = 0; i < N; i++) do_hop(0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R5 aligned lock", int'(locked), 1);
        do_hop(0, 1'b0);
        chk("R2 locked advance", int'(freq_idx), tx & IMASK);

        // restart and hop strobe in the same cycle while locked
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R3 start wins over strobe", int'(freq_idx), SEED & IMASK);
        for (int i = 0; i < N - 1; i++) do_hop(1, 1'b1);
        chk("R3 strobe not counted", int'(busy), 1);
        do_hop(1, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R4 full dwell then lock", int'(locked), 1);

        // start during a dwell is ignored
        do_start(SEED);
        for (int i = 0; i < 3; i++) do_hop(1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) do_hop(1, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R3 busy start ignored", int'(locked), 1);

        // exact threshold boundary
        threshold = 4'd5;
        do_start(SEED);
        dwell_pattern(5);
        chk("R5 sum equals threshold", int'(locked), 1);
        threshold = 4'd6;
        do_start(SEED);
        dwell_pattern(5);
        chk("R5 sum below threshold", int'(locked), 0);
        f = int'(freq_idx);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R6 slip pulse", int'(slip_pulse), 1);
        chk("R6 code held on slip", int'(freq_idx), f);
        dwell_pattern(6);
        chk("R6 fresh dwell sum", int'(locked), 1);

        // threshold zero locks with no matches
        threshold = 4'd0;
        do_start(SEED);
        dwell_pattern(0);
        chk("R5 zero threshold", int'(locked), 1);

        // transmitter three hops behind: serial search slips into alignment
        threshold = 4'd7;
        behind = SEED;
        for (int i = 0; i < NPH - 3; i++) behind = step(behind);
        do_start(behind);
        for (int i = 0; i < 200 && !locked; i++) begin
            if (busy && !locked) do_hop(0, 1'b0);
        end
        chk("R5 offset lock", int'(locked), 1);
        hits = 0;
        for (int i = 0; i < N; i++) begin
            if ((tx & IMASK) == int'(freq_idx)) hits++;
            do_hop(0, 1'b0);
        end
        chk("R6 aligned after slips", hits, N);

        // no matches at all: every phase fails, then timeout
        threshold = 4'd1;
        do_start(SEED);
        for (int i = 0; i < NPH * (N + 1) + 4 && busy; i++) do_hop(1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R7 timeout set", int'(timeout), 1);
        chk("R7 idle after timeout", int'(busy), 0);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R2 idle holds code", int'(freq_idx), SEED & IMASK);
        do_start(SEED);
        chk("R7 start clears timeout", int'(timeout), 0);

        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        finish_up();
    end

endmodule